// File: doc/BRIEF.md
# Wake Trigger Lookup Table with Power-Domain Sequencing

This block decides which processing masters to power up when a wake event arrives. It holds a small table of entries. Each entry names one trigger input, the master it wakes, any extra domains that master needs (the timer domain or another master's domain) and whether the crystal oscillator must run. When a trigger input rises, every valid entry that lists it becomes pending and activated in the same cycle. Software on a master acknowledges its pending entries. When the master later asks for deep sleep, its activated entries are released.

The power-domain enables are computed fresh every cycle from the activated entries. A master domain is on while any activated entry targets it or asks for it as an extra domain. The timer domain works the same way. The shared memory domain is on whenever at least one master domain is on. A register-style write port loads entries, sets entries pending by software and acknowledges them.

Top module: `pwr_wake_table`

## Requirements
- R1: A write with `reg_op`=0 loads entry `reg_idx` from `reg_wdata` using this layout: bit 0 valid, bits 3:1 trigger id, bits 5:4 target master (0..2), bit 6 timer-domain request, bits 9:7 mask of extra master domains, bit 10 oscillator request. The same write clears that entry's pending and activated state, and this clear takes precedence over a trigger in the same cycle.
- R2: A rising edge on `trig_in[t]` sets the pending and activated bits of every valid entry whose trigger id is t, visible after the next clock edge. A trigger held high does not fire again, and one trigger may wake several entries.
- R3: A write with `reg_op`=1 sets pending and activates each valid entry whose bit is set in `reg_wdata`, exactly like a hardware trigger. Bits for invalid entries are ignored.
- R4: A write with `reg_op`=2 clears the pending bits set in `reg_wdata`. If an entry fires in the same cycle, the fire wins and the entry stays pending.
- R5: A master domain enable is high exactly while some activated entry targets that master or lists it in its extra-domain mask. The timer-domain enable is high exactly while some activated entry requests it.
- R6: A sleep request from a master is accepted only in a cycle where no entry targeting that master is pending or firing. An accepted request releases all of that master's activated entries. A refused request changes nothing.
- R7: The memory-domain enable is high exactly when at least one master domain enable is high.
- R8: The oscillator enable turns on when an entry with the oscillator request is activated. It stays on, even after that entry is released, until all master domains are off.
- R9: Invalidating an entry (an R1 write with valid 0) drops every domain that only that entry was holding, on the next clock edge.
- R10: After reset the table is empty and every enable and pending bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | N_TRIG | Wake trigger inputs, edge-detected |
| sleep_req | input | N_MST | Per-master deep-sleep request |
| reg_we | input | 1 | Register write strobe |
| reg_op | input | 2 | 0 entry write, 1 set pending, 2 acknowledge, 3 no operation |
| reg_idx | input | log2(N_ENT) | Entry index for entry writes |
| reg_wdata | input | max(N_ENT,11) | Entry contents or entry bit mask |
| pd_mst_on | output | N_MST | Master power-domain enables |
| pd_tmr_on | output | 1 | Timer power-domain enable |
| pd_mem_on | output | 1 | Shared memory power-domain enable |
| osc_on | output | 1 | Crystal oscillator enable |
| pend_o | output | N_ENT | Pending entry bits |

## Verification
The bench uses the default parameters: 16 entries, 8 trigger inputs and 3 masters. With these values, two entries can share one trigger and a third entry can borrow another master's domain. The bench checks the per-master release against extra-domain requests and the refusal of sleep while an entry is pending. It also covers the same-cycle fire-versus-acknowledge case, the oscillator hold, and invalidation of the only entry keeping a master alive.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
    localparam int N_MST  = 3;
    localparam int MST_W  = 2;
    localparam int N_TRIG = 8;
    localparam int TRIG_W = $clog2(N_TRIG);

    // Field order fixes the bit positions software writes (valid at bit 0).
    typedef struct packed {
        logic              osc;
        logic [N_MST-1:0]  xmst;
        logic              tmr;
        logic [MST_W-1:0]  mst;
        logic [TRIG_W-1:0] trig;
        logic              valid;
    } ent_t;

    localparam int ENT_W = $bits(ent_t);

    typedef enum logic [1:0] {
        OP_WRENT   = 2'd0,
        OP_SETPEND = 2'd1,
        OP_ACK     = 2'd2,
        OP_NONE    = 2'd3
    } op_e;
endpackage

// File: rtl/pwt_edge.sv
module pwt_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/pwt_table.sv
module pwt_table
    import pwt_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  ent_t                   wr_ent,
    input  logic [N_TRIG-1:0]      rise,
    output ent_t [N_ENT-1:0]       ents,
    output logic [N_ENT-1:0]       live,
    output logic [N_ENT-1:0]       hw_hit
);
    ent_t [N_ENT-1:0] ents_d, ents_q;

    always_comb begin
        ents_d = ents_q;
        if (wr_en) ents_d[wr_idx] = wr_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ents_q <= '0;
        else        ents_q <= ents_d;
    end

    // An entry naming a master code outside the table of masters never matches.
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        assign live[e]   = ents_q[e].valid && (int'(ents_q[e].mst) < N_MST);
        assign hw_hit[e] = live[e] && rise[ents_q[e].trig];
    end

    assign ents = ents_q;
endmodule

// File: rtl/pwt_domains.sv
module pwt_domains
    import pwt_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  ent_t [N_ENT-1:0]              ents,
    input  logic [N_ENT-1:0]              live,
    input  logic [N_ENT-1:0]              act,
    output logic [N_MST-1:0][N_ENT-1:0]   tgt,
    output logic [N_MST-1:0]              mst_on,
    output logic                          tmr_on
);
    logic [N_MST-1:0][N_ENT-1:0] xreq;
    logic [N_ENT-1:0]            tmr_req;

    for (genvar m = 0; m < N_MST; m++) begin : g_mst
        for (genvar e = 0; e < N_ENT; e++) begin : g_ent
            assign tgt[m][e]  = live[e] && (ents[e].mst == MST_W'(m));
            assign xreq[m][e] = live[e] && ents[e].xmst[m];
        end
        assign mst_on[m] = |(act & (tgt[m] | xreq[m]));
    end

    for (genvar e = 0; e < N_ENT; e++) begin : g_tmr
        assign tmr_req[e] = live[e] && ents[e].tmr;
    end

    assign tmr_on = |(act & tmr_req);
endmodule

// File: rtl/pwr_wake_table.sv
module pwr_wake_table
    import pwt_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int DW    = (N_ENT > ENT_W) ? N_ENT : ENT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_TRIG-1:0]   trig_in,
    input  logic [N_MST-1:0]    sleep_req,
    input  logic                reg_we,
    input  logic [1:0]          reg_op,
    input  logic [IDX_W-1:0]    reg_idx,
    input  logic [DW-1:0]       reg_wdata,
    output logic [N_MST-1:0]    pd_mst_on,
    output logic                pd_tmr_on,
    output logic                pd_mem_on,
    output logic                osc_on,
    output logic [N_ENT-1:0]    pend_o
);
    typedef struct packed {
        logic [N_ENT-1:0] pend;
        logic [N_ENT-1:0] act;
        logic             osc;
    } st_t;

    st_t st_d, st_q;

    logic [N_TRIG-1:0]           rise;
    ent_t [N_ENT-1:0]            ents;
    logic [N_ENT-1:0]            live;
    logic [N_ENT-1:0]            hw_hit;
    logic [N_MST-1:0][N_ENT-1:0] tgt;
    logic [N_MST-1:0]            mst_on;
    logic                        tmr_on;

    logic                        wr_ent_en;
    logic [N_ENT-1:0]            wr_mask;
    logic [N_ENT-1:0]            sw_fire;
    logic [N_ENT-1:0]            ack_mask;
    logic [N_ENT-1:0]            fire;
    logic [N_ENT-1:0]            rel_mask;
    logic [N_ENT-1:0]            osc_req;
    logic [N_MST-1:0]            slp_ok;

    assign wr_ent_en = reg_we && (op_e'(reg_op) == OP_WRENT);

    pwt_edge #(.W(N_TRIG)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (trig_in),
        .rise_o (rise)
    );

    pwt_table #(.N_ENT(N_ENT)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ent_en),
        .wr_idx (reg_idx),
        .wr_ent (ent_t'(reg_wdata[ENT_W-1:0])),
        .rise   (rise),
        .ents   (ents),
        .live   (live),
        .hw_hit (hw_hit)
    );

    pwt_domains #(.N_ENT(N_ENT)) u_dom (
        .ents   (ents),
        .live   (live),
        .act    (st_q.act),
        .tgt    (tgt),
        .mst_on (mst_on),
        .tmr_on (tmr_on)
    );

    for (genvar e = 0; e < N_ENT; e++) begin : g_osc
        assign osc_req[e] = ents[e].osc;
    end

    always_comb begin
        st_d     = st_q;
        wr_mask  = '0;
        sw_fire  = '0;
        ack_mask = '0;
        rel_mask = '0;
        slp_ok   = '0;

        if (wr_ent_en) wr_mask[reg_idx] = 1'b1;
        if (reg_we && (op_e'(reg_op) == OP_SETPEND)) sw_fire  = reg_wdata[N_ENT-1:0] & live;
        if (reg_we && (op_e'(reg_op) == OP_ACK))     ack_mask = reg_wdata[N_ENT-1:0];

        // Entry writes override any trigger of the same entry.
        fire = (hw_hit | sw_fire) & ~wr_mask;

        // Sleep is refused while the master has anything pending or firing.
        for (int m = 0; m < N_MST; m++) begin
            slp_ok[m] = sleep_req[m]
                     && ((st_q.pend & tgt[m]) == '0)
                     && ((fire & tgt[m]) == '0);
            if (slp_ok[m]) rel_mask = rel_mask | tgt[m];
        end

        st_d.pend = ((st_q.pend & ~ack_mask) | fire) & ~wr_mask;
        st_d.act  = ((st_q.act  & ~rel_mask) | fire) & ~wr_mask;
        st_d.osc  = (|st_d.act) && (st_q.osc || ((fire & osc_req) != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pd_mst_on = mst_on;
    assign pd_tmr_on = tmr_on;
    assign pd_mem_on = |mst_on;
    assign osc_on    = st_q.osc;
    assign pend_o    = st_q.pend;
endmodule

// File: rtl/pwt_chk.sv
module pwt_chk
    import pwt_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int DW    = (N_ENT > ENT_W) ? N_ENT : ENT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_TRIG-1:0] trig_in,
    input logic              reg_we,
    input logic [1:0]        reg_op,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [DW-1:0]     reg_wdata,
    input logic [N_MST-1:0]  pd_mst_on,
    input logic              pd_tmr_on,
    input logic              pd_mem_on,
    input logic              osc_on,
    input logic [N_ENT-1:0]  pend_o
);
    logic [N_TRIG-1:0] tp_q;
    logic [N_TRIG-1:0] rise_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= trig_in;
    end
    assign rise_c = trig_in & ~tp_q;

    // R7
    mem_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_mem_on == (|pd_mst_on));

    // R8
    osc_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_on |-> pd_mem_on);

    // R5
    tmr_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_tmr_on |-> (|pd_mst_on));

    // R2
    new_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_c == '0 && !(reg_we && reg_op == OP_SETPEND))
        |=> ((pend_o & ~$past(pend_o)) == '0));

    // R4
    ack_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_op == OP_ACK && (&reg_wdata[N_ENT-1:0]) && rise_c == '0)
        |=> (pend_o == '0));

    // R1
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_op == OP_WRENT) |=> !pend_o[$past(reg_idx)]);
endmodule

bind pwr_wake_table pwt_chk #(.N_ENT(N_ENT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_in   (trig_in),
    .reg_we    (reg_we),
    .reg_op    (reg_op),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .pd_mst_on (pd_mst_on),
    .pd_tmr_on (pd_tmr_on),
    .pd_mem_on (pd_mem_on),
    .osc_on    (osc_on),
    .pend_o    (pend_o)
);

// File: tb/sim_pwr_wake_table.sv
module sim_pwr_wake_table;
    import pwt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  trig_in = '0;
    logic [2:0]  sleep_req = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_op = 2'd3;
    logic [3:0]  reg_idx = '0;
    logic [15:0] reg_wdata = '0;
    logic [2:0]  pd_mst_on;
    logic        pd_tmr_on, pd_mem_on, osc_on;
    logic [15:0] pend_o;

    always #10 clk = ~clk;

    pwr_wake_table u0 (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sleep_req(sleep_req),
        .reg_we(reg_we), .reg_op(reg_op), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .pd_mst_on(pd_mst_on), .pd_tmr_on(pd_tmr_on), .pd_mem_on(pd_mem_on),
        .osc_on(osc_on), .pend_o(pend_o)
    );

    typedef struct {
        string       tag;
        logic [15:0] pend;
        logic [2:0]  mst;
        logic        tmr;
        logic        mem;
        logic        osc;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Monitor: compares 5 ns after each rising edge.
    always @(posedge clk) begin
        #5;
        if (sb.size() > 0) begin
            cur = sb.pop_front();
            n_cmp++;
            if (pend_o !== cur.pend || pd_mst_on !== cur.mst || pd_tmr_on !== cur.tmr ||
                pd_mem_on !== cur.mem || osc_on !== cur.osc) begin
                n_bad++;
                $display("FAIL %s: got pend=%h mst=%b tmr=%b mem=%b osc=%b, expected pend=%h mst=%b tmr=%b mem=%b osc=%b",
                         cur.tag, pend_o, pd_mst_on, pd_tmr_on, pd_mem_on, osc_on,
                         cur.pend, cur.mst, cur.tmr, cur.mem, cur.osc);
            end
        end
    end

    function automatic logic [15:0] ent(input logic v, input logic [2:0] t, input logic [1:0] m,
                                        input logic tm, input logic [2:0] xm, input logic o);
        return {5'b0, o, xm, tm, m, t, v};
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected outcome.
    task automatic cyc(input string tag, input logic [7:0] t, input logic [2:0] s,
                       input logic we, input logic [1:0] op, input logic [3:0] idx,
                       input logic [15:0] wd, input logic [15:0] ep, input logic [2:0] em,
                       input logic et, input logic emem, input logic eo);
        exp_t x;
        @(negedge clk);
        trig_in = t; sleep_req = s; reg_we = we; reg_op = op; reg_idx = idx; reg_wdata = wd;
        x.tag = tag; x.pend = ep; x.mst = em; x.tmr = et; x.mem = emem; x.osc = eo;
        sb.push_back(x);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        cyc("R10 reset", 8'h00, 3'b000, 0, 2'd3, 4'd0, 16'h0, 16'h0, 3'b000, 0, 0, 0);
        // R1 entry loads; nothing fires
        cyc("R1 wr e0", 8'h00, 3'b000, 1, 2'd0, 4'd0, ent(1, 3'd2, 2'd0, 1, 3'b000, 1), 16'h0, 3'b000, 0, 0, 0);
        cyc("R1 wr e1", 8'h00, 3'b000, 1, 2'd0, 4'd1, ent(1, 3'd2, 2'd1, 0, 3'b000, 0), 16'h0, 3'b000, 0, 0, 0);
        cyc("R1 wr e2", 8'h00, 3'b000, 1, 2'd0, 4'd2, ent(1, 3'd5, 2'd2, 0, 3'b001, 0), 16'h0, 3'b000, 0, 0, 0);
        cyc("R1 wr e3", 8'h00, 3'b000, 1, 2'd0, 4'd3, ent(0, 3'd5, 2'd1, 0, 3'b000, 0), 16'h0, 3'b000, 0, 0, 0);
        // R2 shared trigger wakes two masters; R5 timer; R7 mem; R8 osc
        cyc("R2 rise t2", 8'h04, 3'b000, 0, 2'd3, 4'd0, 16'h0, 16'h0003, 3'b011, 1, 1, 1);
        cyc("R2 held t2", 8'h04, 3'b000, 0, 2'd3, 4'd0, 16'h0, 16'h0003, 3'b011, 1, 1, 1);
        cyc("R4 ack e0", 8'h04, 3'b000, 1, 2'd2, 4'd0, 16'h0001, 16'h0002, 3'b011, 1, 1, 1);
        // R6 accepted sleep; R8 osc held by remaining master
        cyc("R6 sleep m0", 8'h04, 3'b001, 0, 2'd3, 4'd0, 16'h0, 16'h0002, 3'b010, 0, 1, 1);
        cyc("R6 refused m1", 8'h04, 3'b010, 0, 2'd3, 4'd0, 16'h0, 16'h0002, 3'b010, 0, 1, 1);
        cyc("R6 ack same cyc", 8'h04, 3'b010, 1, 2'd2, 4'd0, 16'h0002, 16'h0000, 3'b010, 0, 1, 1);
        cyc("R8 all asleep", 8'h04, 3'b010, 0, 2'd3, 4'd0, 16'h0, 16'h0000, 3'b000, 0, 0, 0);
        // R2 invalid entry with same trigger ignored; R5 extra master domain
        cyc("R5 rise t5", 8'h24, 3'b000, 0, 2'd3, 4'd0, 16'h0, 16'h0004, 3'b101, 0, 1, 0);
        cyc("R4 ack e2", 8'h24, 3'b000, 1, 2'd2, 4'd0, 16'h0004, 16'h0000, 3'b101, 0, 1, 0);
        cyc("R3 set e1", 8'h24, 3'b000, 1, 2'd1, 4'd0, 16'h0002, 16'h0002, 3'b111, 0, 1, 0);
        cyc("R3 set invalid e3", 8'h24, 3'b000, 1, 2'd1, 4'd0, 16'h0008, 16'h0002, 3'b111, 0, 1, 0);
        // R9 invalidation drops domains
        cyc("R9 inval e1", 8'h24, 3'b000, 1, 2'd0, 4'd1, ent(0, 3'd2, 2'd1, 0, 3'b000, 0), 16'h0000, 3'b101, 0, 1, 0);
        cyc("R9 inval e2", 8'h24, 3'b000, 1, 2'd0, 4'd2, ent(0, 3'd5, 2'd2, 0, 3'b001, 0), 16'h0000, 3'b000, 0, 0, 0);
        cyc("R1 reload e1", 8'h24, 3'b000, 1, 2'd0, 4'd1, ent(1, 3'd2, 2'd1, 0, 3'b000, 0), 16'h0, 3'b000, 0, 0, 0);
        cyc("R1 reload e2", 8'h24, 3'b000, 1, 2'd0, 4'd2, ent(1, 3'd5, 2'd2, 0, 3'b001, 0), 16'h0, 3'b000, 0, 0, 0);
        cyc("R2 fall no fire", 8'h20, 3'b000, 0, 2'd3, 4'd0, 16'h0, 16'h0, 3'b000, 0, 0, 0);
        // R4 fire beats acknowledge in the same cycle
        cyc("R4 fire vs ack", 8'h24, 3'b000, 1, 2'd2, 4'd0, 16'h0001, 16'h0003, 3'b011, 1, 1, 1);
        cyc("R4 ack both", 8'h24, 3'b000, 1, 2'd2, 4'd0, 16'h0003, 16'h0000, 3'b011, 1, 1, 1);
        cyc("R8 osc kept", 8'h24, 3'b001, 0, 2'd3, 4'd0, 16'h0, 16'h0000, 3'b010, 0, 1, 1);
        cyc("R8 osc off", 8'h24, 3'b010, 0, 2'd3, 4'd0, 16'h0, 16'h0000, 3'b000, 0, 0, 0);
        cyc("R2 drop t5", 8'h04, 3'b000, 0, 2'd3, 4'd0, 16'h0, 16'h0000, 3'b000, 0, 0, 0);
        cyc("R5 rise t5 again", 8'h24, 3'b000, 0, 2'd3, 4'd0, 16'h0, 16'h0004, 3'b101, 0, 1, 0);
        cyc("R3 set e0", 8'h24, 3'b000, 1, 2'd1, 4'd0, 16'h0001, 16'h0005, 3'b101, 1, 1, 1);
        cyc("R4 ack e0 e2", 8'h24, 3'b000, 1, 2'd2, 4'd0, 16'h0005, 16'h0000, 3'b101, 1, 1, 1);
        // R5 borrowed domain survives its own master's sleep
        cyc("R5 m0 held by e2", 8'h24, 3'b001, 0, 2'd3, 4'd0, 16'h0, 16'h0000, 3'b101, 0, 1, 1);
        cyc("R6 sleep m2", 8'h24, 3'b100, 0, 2'd3, 4'd0, 16'h0, 16'h0000, 3'b000, 0, 0, 0);
        // R1 rewriting a pending entry clears it
        cyc("R3 set e1 again", 8'h24, 3'b000, 1, 2'd1, 4'd0, 16'h0002, 16'h0002, 3'b010, 0, 1, 0);
        cyc("R1 rewrite clears", 8'h24, 3'b000, 1, 2'd0, 4'd1, ent(1, 3'd2, 2'd1, 0, 3'b000, 0), 16'h0000, 3'b000, 0, 0, 0);
        cyc("R10 idle", 8'h24, 3'b000, 0, 2'd3, 4'd0, 16'h0, 16'h0000, 3'b000, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule